// File: doc/BRIEF.md
# Byte-Wide SPI Master with Polled Register Interface

This block is a single-lane SPI master controlled through four 32-bit word registers. Software configures the serial clock divider, clock polarity and clock phase, then drives up to four chip-select lines directly by setting and clearing enable bits. A transfer always moves exactly one byte in both directions at once. Writing a byte into the transmit register starts it. The incoming byte is captured from the serial input and becomes readable from the receive register.

Software keeps transfers in order by polling a ready flag. The flag drops when a byte starts and rises again when the byte has finished. To read a byte without sending anything, software writes 0x00 and still gets a complete shift. A configuration bit requests a FIFO flush. There is no FIFO, so the request only runs a short fixed countdown and then clears itself. The FIFO-enable and two-byte-length bits are accepted on write but always read back as zero, so the block stays in single-byte operation.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control register (word offset 0x0) reads 0x0000_0002 (ready flag in bit 1 set, no select enabled), the configuration register (offset 0x4) reads 0, every `cs_n` line is high and `sclk` is low.
- R2: Control bits 16+n (n = 0..3) are chip-select enables: a written 1 drives `cs_n[n]` low, a 0 drives it high, and the enables read back in the same bit positions.
- R3: Configuration bits [4:0] (prescale code), 6 (phase) and 7 (polarity) read back as written; bits 5 (byte length) and 17 (FIFO enable) accept writes but always read back 0.
- R4: While no transfer is running, `sclk` rests at the polarity bit value (0 idles low, 1 idles high).
- R5: A write to the transmit register (offset 0x8) while ready is set starts a transfer, clears the ready flag, and shifts the byte out on `mosi` MSB first; writing 0x00 still performs a full eight-bit shift.
- R6: At the end of a transfer, the eight bits sampled from `miso` (first bit as bit 7) appear in bits [7:0] of the receive register (offset 0xC), with bits [31:8] zero.
- R7: The prescale code gives the divisor D: code 0 gives 1, codes 1..15 give the code itself, code 0x10+k gives 2k for k >= 1, and code 0x10 gives 2. Each `sclk` half period lasts D clock cycles, so the ready flag stays low for exactly 16*D cycles.
- R8: A write to the transmit register while a transfer is running is ignored: the byte being sent, the duration and the received data are unchanged, and no second transfer follows.
- R9: Writing 1 to configuration bit 9 sets the flush flag. The flag reads 1 for FLUSH_CYCLES cycles and then clears itself.
- R10: With phase 0, data is valid before the first `sclk` edge and is sampled on leading edges. With phase 1, data changes on leading edges and is sampled on trailing edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register word (bits [3:2] used) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | CS_NUM | Active-low chip selects |

## Verification
The hardest case to reach is a write to the transmit register while a shift is in progress, because software normally waits on the ready flag. The bench polls the ready flag itself and sends a second write partway through a transfer, on a divider large enough that the transfer is clearly still running. It then checks that the slave model captures only the original byte, that the transfer takes its normal length, and that no further clock edges follow. All four polarity and phase combinations are covered against a slave model that switches its sampling edge with the mode.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int CS_NUM       = 4,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_NUM-1:0] cs_n
);
  localparam int FW = $clog2(FLUSH_CYCLES + 1);
  localparam logic [FW-1:0] FLUSH_LOAD = FW'(FLUSH_CYCLES);

  logic [CS_NUM-1:0] cs_en;
  logic [4:0]        pre_code;
  logic              cfg_pha, cfg_pol;
  logic [FW-1:0]     fl_cnt;
  logic              busy, lvl, pha_q;
  logic [4:0]        div_q, cnt;
  logic [3:0]        edge_i;
  logic [7:0]        tx_sr, rx_sr, rx_byte;

  function automatic logic [4:0] divisor(input logic [4:0] code);
    if (code == 5'd0)       return 5'd1;
    else if (!code[4])      return code;
    else if (code == 5'h10) return 5'd2;
    else                    return {code[3:0], 1'b0};
  endfunction

  wire wr_ctrl = bus_wr && bus_addr[3:2] == 2'd0;
  wire wr_cfg  = bus_wr && bus_addr[3:2] == 2'd1;
  wire wr_dout = bus_wr && bus_addr[3:2] == 2'd2;
  wire start   = wr_dout && !busy;
  wire tick    = busy && (cnt == div_q - 5'd1);
  wire smp     = (edge_i[0] == pha_q);
  wire shf     = !smp && (edge_i != 4'd0);
  wire last    = (edge_i == 4'd15);

  assign sclk = cfg_pol ^ lvl;
  assign mosi = tx_sr[7];
  assign cs_n = ~cs_en;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr[3:2])
      2'd0: begin
        bus_rdata[1]             = !busy;
        bus_rdata[16 +: CS_NUM]  = cs_en;
      end
      2'd1: begin
        bus_rdata[4:0] = pre_code;
        bus_rdata[6]   = cfg_pha;
        bus_rdata[7]   = cfg_pol;
        bus_rdata[9]   = (fl_cnt != '0);
      end
      2'd3: bus_rdata[7:0] = rx_byte;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en    <= '0;
      pre_code <= '0;
      cfg_pha  <= 1'b0;
      cfg_pol  <= 1'b0;
      fl_cnt   <= '0;
    end else begin
      if (wr_ctrl) cs_en <= bus_wdata[16 +: CS_NUM];
      if (wr_cfg) begin
        pre_code <= bus_wdata[4:0];
        cfg_pha  <= bus_wdata[6];
        cfg_pol  <= bus_wdata[7];
      end
      if (wr_cfg && bus_wdata[9]) fl_cnt <= FLUSH_LOAD;
      else if (fl_cnt != '0)      fl_cnt <= fl_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      lvl     <= 1'b0;
      pha_q   <= 1'b0;
      div_q   <= 5'd1;
      cnt     <= '0;
      edge_i  <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      lvl    <= 1'b0;
      pha_q  <= cfg_pha;
      div_q  <= divisor(pre_code);
      cnt    <= '0;
      edge_i <= '0;
      tx_sr  <= bus_wdata[7:0];
    end else if (tick) begin
      cnt    <= '0;
      lvl    <= ~lvl;
      edge_i <= edge_i + 4'd1;
      if (smp) rx_sr <= {rx_sr[6:0], miso};
      if (shf) tx_sr <= {tx_sr[6:0], 1'b0};
      if (last) begin
        busy    <= 1'b0;
        rx_byte <= smp ? {rx_sr[6:0], miso} : rx_sr;
      end
    end else if (busy) begin
      cnt <= cnt + 5'd1;
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cfg_pol); // R4
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && mosi == $past(bus_wdata[7]) && bus_rdata[1] == 1'b0 || bus_addr[3:2] != 2'd0)); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_dout && !tick) |=> ($stable(div_q) && $stable(pha_q) && $stable(tx_sr) && busy)); // R8
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (div_q >= 5'd1 && div_q <= 5'd30)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last && !wr_cfg) |=> (!busy && sclk == cfg_pol)); // R7
  AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cnt <= FLUSH_LOAD); // R9
endmodule

// File: tb/test_spi_byte_master.sv
module test_spi_byte_master;
  localparam int CLK_PERIOD = 10;
  localparam int FLUSH_CYCLES = 4;

  logic clk = 0, rst_n = 0, bus_wr = 0, miso = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sclk, mosi;
  logic [3:0] cs_n;

  int checks = 0, errors = 0;
  bit done = 0;

  spi_byte_master #(.CS_NUM(4), .FLUSH_CYCLES(FLUSH_CYCLES)) i_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model and scoreboard
  logic [7:0] exp_mosi[$];
  logic [7:0] exp_rx[$];
  bit s_on = 0, b_pol = 0, b_pha = 0;
  logic [7:0] s_tx, s_rx;
  int s_out, s_smp;

  always @(posedge sclk or negedge sclk) begin
    if (s_on) begin
      if ((sclk != b_pol) != b_pha) begin
        s_rx = {s_rx[6:0], mosi};
        s_smp++;
        if (s_smp == 8) begin
          if (exp_mosi.size() == 0) chk("R8 unexpected byte", 32'(s_rx), 32'hDEAD);
          else chk("R5/R10 mosi byte", 32'(s_rx), 32'(exp_mosi.pop_front()));
        end
        if (s_smp > 8) chk("R8 extra sample", 32'(s_smp), 32'd8);
      end else if (s_out < 8) begin
        miso = s_tx[7 - s_out];
        s_out++;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic xfer(input logic [4:0] code, input bit pol, input bit pha,
                      input logic [7:0] tx, input logic [7:0] stx,
                      input int dv, input bit poke);
    logic [31:0] r;
    int cyc;
    s_on = 0;
    wr(4'h4, {24'd0, pol, pha, 1'b0, code});
    b_pol = pol; b_pha = pha;
    s_tx = stx; s_rx = 0; s_smp = 0;
    if (pha == 0) begin miso = stx[7]; s_out = 1; end
    else s_out = 0;
    exp_mosi.push_back(tx);
    exp_rx.push_back(stx);
    s_on = 1;
    wr(4'h8, {24'd0, tx});
    cyc = 0;
    forever begin
      bus_addr = 4'h0; bus_wr = 0;
      #1 r = bus_rdata;
      if (r[1]) break;
      cyc++;
      if (poke && cyc == 5) begin
        bus_addr = 4'h8; bus_wdata = 32'hFF; bus_wr = 1;
      end
      @(negedge clk);
      if (cyc > 2000) break;
    end
    chk("R7 ready low cycles", 32'(cyc), 32'(16 * dv));
    rd(4'hC, r);
    chk("R6 din", r, 32'(exp_rx.pop_front()));
    repeat (3 * dv) @(negedge clk);
    chk("R8 no restart", 32'(s_smp), 32'd8);
    chk("R5 scoreboard drained", 32'(exp_mosi.size()), 32'd0);
    chk("R4 idle level", 32'(sclk), 32'(pol));
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(4'h0, r); chk("R1 ctrl reset", r, 32'h2);
    rd(4'h4, r); chk("R1 cfg reset", r, 32'h0);
    chk("R1 cs_n reset", 32'(cs_n), 32'hF);
    chk("R1 sclk reset", 32'(sclk), 32'h0);

    wr(4'h0, 32'h000A_0000);
    chk("R2 cs_n", 32'(cs_n), 32'h5);
    rd(4'h0, r); chk("R2 ctrl readback", r, 32'h000A_0002);

    wr(4'h4, 32'h0002_00E3);
    rd(4'h4, r); chk("R3 cfg readback", r, 32'h0000_00C3);
    chk("R4 sclk idles high", 32'(sclk), 32'h1);

    wr(4'h4, 32'h0000_0200);
    rd(4'h4, r); chk("R9 flush set", r, 32'h200);
    repeat (FLUSH_CYCLES - 1) @(negedge clk);
    rd(4'h4, r); chk("R9 flush held", r, 32'h200);
    @(negedge clk);
    rd(4'h4, r); chk("R9 flush cleared", r, 32'h0);

    wr(4'h0, 32'h0001_0000);
    chk("R2 cs0 active", 32'(cs_n), 32'hE);
    xfer(5'h00, 0, 0, 8'hA5, 8'h3C, 1, 0);
    xfer(5'h03, 0, 1, 8'h81, 8'h7E, 3, 0);
    xfer(5'h10, 1, 0, 8'h00, 8'hC9, 2, 0);
    xfer(5'h13, 1, 1, 8'h5A, 8'h01, 6, 0);
    xfer(5'h1F, 0, 0, 8'hFF, 8'h80, 30, 0);
    xfer(5'h02, 0, 1, 8'h96, 8'h69, 2, 1);
    xfer(5'h0F, 1, 0, 8'h3D, 8'hE2, 15, 1);
    s_on = 0;
    wr(4'h0, 32'h0);
    chk("R2 cs released", 32'(cs_n), 32'hF);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule